// File: doc/BRIEF.md
# Stream Link Throughput and Round-Trip Tester

This block is a traffic core that sits at both ends of a FIFO-like stream link between two boards and measures it. It has one outgoing stream, one incoming stream and a handful of plain control and status pins that a processor drives and reads. A test begins with a one-cycle start pulse that also latches a mode, a word count and a timeout limit. When the test ends, the result stays in the status outputs until the next start.

There are four modes. Two instances run a throughput test as a pair: the source writes an incrementing pattern whenever the link accepts a word and counts clock cycles until the programmed amount has gone out, while the sink takes every word that arrives and flags any word that breaks the sequence. Two instances also run a round-trip test as a pair: the initiator sends one word and counts the cycles until one word comes back, while the responder returns every word it receives unchanged.

Both streams use valid/ready. A word moves in a cycle where valid and ready are both high at the rising edge. The outgoing side keeps valid high and data stable until the word is accepted, so back-pressure from the link stalls the source. The incoming side raises ready only in the modes and phases that take data.

Top module: `linktest_core`

## Requirements
- R1: After reset, and whenever no test is running, busy, done, timeout and mismatch are low, the cycle result is zero until a test runs, tx_valid is low and rx_ready is low.
- R2: In source mode (cfg_mode = 0) the core offers a word on every busy cycle. The words are 0, 1, 2 and so on, zero-extended to the data width. A word advances only once it has been accepted.
- R3: In source mode the result is the number of busy cycles, counted from the cycle after the start through the cycle in which the last of the cfg_count words is accepted. At that edge done rises and busy falls, and the result then holds until the next start.
- R4: In sink mode (cfg_mode = 1) rx_ready is high on every busy cycle until cfg_count words have been taken. The result is the number of busy cycles, and done rises with the last word.
- R5: In sink mode the mismatch flag is set, and stays set until the next start, if the k-th received word (counting from 0) is not equal to k.
- R6: In ping mode (cfg_mode = 2) exactly one word is sent, equal to cfg_count zero-extended. After that word is accepted, rx_ready stays high and the count rises by one per cycle, including the cycle in which the reply arrives. The reply sets done, and sets mismatch if it differs from the word sent.
- R7: In ping mode with a nonzero cfg_limit, if no reply has arrived when the count reaches cfg_limit, done and timeout are set, the result equals cfg_limit and rx_ready drops. A limit of zero waits forever.
- R8: In responder mode (cfg_mode = 3) every accepted word is sent back unchanged. Only one word is held at a time, and rx_ready stays low while a word waits to go out. The result counts the words returned, and done never rises.
- R9: The cycle result saturates at its all-ones value instead of wrapping.
- R10: A start pulse is taken in any state. It abandons the running test, clears done, timeout, mismatch and the result, and empties the held reply word. In source or sink mode a count of zero sets done at once with a result of zero.
- R11: Once tx_valid is high and the word has not been accepted, tx_valid stays high and tx_data stays stable in the next cycle, unless a start pulse intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse that launches a test |
| cfg_mode | input | 2 | 0 source, 1 sink, 2 ping, 3 responder; sampled on start |
| cfg_count | input | CNT_W | Word count for source and sink, payload for ping; sampled on start |
| cfg_limit | input | CNT_W | Ping timeout in cycles, 0 disables; sampled on start |
| stat_busy | output | 1 | A test is running |
| stat_done | output | 1 | The last test finished |
| stat_timeout | output | 1 | The ping gave up waiting |
| stat_mismatch | output | 1 | Out-of-sequence or corrupted data was seen |
| stat_cycles | output | CNT_W | Cycle count, or words echoed in responder mode |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Link accepts the outgoing word |
| tx_data | output | DATA_W | Outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Core accepts the incoming word |
| rx_data | input | DATA_W | Incoming word |

## Verification
The assertions check every cycle that an idle core drives neither stream and that a stalled outgoing word is held. They also check that the result never goes backwards during a test, that a finished result stays frozen, and that a start leaves the flags and the count cleared. Exact cycle counts under varying back-pressure, the sequence and echo comparisons, the timeout boundary, saturation and the single-slot behaviour of the responder can only be shown by the bench scenarios. There, a behavioural model of the four modes predicts every output on every clock.

// File: rtl/linktest_pkg.sv
package linktest_pkg;

  typedef enum logic [1:0] {
    MODE_PUSH = 2'd0,
    MODE_PULL = 2'd1,
    MODE_PING = 2'd2,
    MODE_ECHO = 2'd3
  } lt_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_PULL,
    ST_PING_TX,
    ST_PING_WAIT,
    ST_ECHO
  } lt_state_e;

endpackage

// File: rtl/lt_sat_counter.sv
module lt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  logic [W-1:0] cnt_q;
  logic         full;

  assign full  = &cnt_q;
  assign value = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && !full) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/lt_echo_slot.sv
module lt_echo_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (!full_q && in_valid) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (full_q && out_ready) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/linktest_core.sv
module linktest_core
  import linktest_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [1:0]        cfg_mode,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [CNT_W-1:0]  cfg_limit,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_timeout,
  output logic              stat_mismatch,
  output logic [CNT_W-1:0]  stat_cycles,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data
);

  localparam int CW1 = CNT_W + 1;

  lt_state_e          state_q;
  logic               done_q, tmo_q, mis_q;
  logic [CNT_W-1:0]   target_q, limit_q;
  logic [DATA_W-1:0]  ping_q;

  logic [CNT_W-1:0]   cycles, words;
  logic               cyc_inc, word_inc;
  logic [CNT_W-1:0]   cyc_after;
  logic [CW1-1:0]     words_next;
  logic               last_word;
  logic               tx_hs, rx_hs;

  logic               slot_in_valid, slot_in_ready, slot_out_valid, slot_out_ready;
  logic [DATA_W-1:0]  slot_out_data;
  logic [DATA_W-1:0]  seq_word;

  // cycle counter, cleared by start
  lt_sat_counter #(.W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_start),
    .inc   (cyc_inc),
    .value (cycles)
  );

  // word counter, doubles as the sequence pattern
  lt_sat_counter #(.W(CNT_W)) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_start),
    .inc   (word_inc),
    .value (words)
  );

  lt_echo_slot #(.W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_start),
    .in_valid  (slot_in_valid),
    .in_ready  (slot_in_ready),
    .in_data   (rx_data),
    .out_valid (slot_out_valid),
    .out_ready (slot_out_ready),
    .out_data  (slot_out_data)
  );

  assign seq_word       = DATA_W'(words);
  assign slot_in_valid  = rx_valid && (state_q == ST_ECHO);
  assign slot_out_ready = tx_ready && (state_q == ST_ECHO);

  // outgoing stream mux
  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    unique case (state_q)
      ST_PUSH: begin
        tx_valid = 1'b1;
        tx_data  = seq_word;
      end
      ST_PING_TX: begin
        tx_valid = 1'b1;
        tx_data  = ping_q;
      end
      ST_ECHO: begin
        tx_valid = slot_out_valid;
        tx_data  = slot_out_data;
      end
      default: ;
    endcase
  end

  // incoming stream ready
  always_comb begin
    unique case (state_q)
      ST_PULL, ST_PING_WAIT: rx_ready = 1'b1;
      ST_ECHO:               rx_ready = slot_in_ready;
      default:               rx_ready = 1'b0;
    endcase
  end

  assign tx_hs = tx_valid && tx_ready;
  assign rx_hs = rx_valid && rx_ready;

  always_comb begin
    unique case (state_q)
      ST_PUSH, ST_PULL, ST_PING_WAIT: cyc_inc = 1'b1;
      ST_ECHO:                        cyc_inc = tx_hs;
      default:                        cyc_inc = 1'b0;
    endcase
  end

  assign word_inc   = ((state_q == ST_PUSH) && tx_hs) || ((state_q == ST_PULL) && rx_hs);
  assign words_next = {1'b0, words} + CW1'(1);
  assign last_word  = (words_next == {1'b0, target_q});
  assign cyc_after  = (&cycles) ? cycles : cycles + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      mis_q    <= 1'b0;
      target_q <= '0;
      limit_q  <= '0;
      ping_q   <= '0;
    end else if (cfg_start) begin
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      mis_q    <= 1'b0;
      target_q <= cfg_count;
      limit_q  <= cfg_limit;
      ping_q   <= DATA_W'(cfg_count);
      case (lt_mode_e'(cfg_mode))
        MODE_PUSH: begin
          if (cfg_count == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_PUSH;
          end
        end
        MODE_PULL: begin
          if (cfg_count == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_PULL;
          end
        end
        MODE_PING: state_q <= ST_PING_TX;
        MODE_ECHO: state_q <= ST_ECHO;
        default:   state_q <= ST_IDLE;
      endcase
    end else begin
      case (state_q)
        ST_PUSH: begin
          if (tx_hs && last_word) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_PULL: begin
          if (rx_hs) begin
            if (rx_data != seq_word) mis_q <= 1'b1;
            if (last_word) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_PING_TX: begin
          if (tx_hs) state_q <= ST_PING_WAIT;
        end
        ST_PING_WAIT: begin
          if (rx_hs) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            mis_q   <= (rx_data != ping_q);
          end else if ((limit_q != '0) && (cyc_after >= limit_q)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign stat_busy     = (state_q != ST_IDLE);
  assign stat_done     = done_q;
  assign stat_timeout  = tmo_q;
  assign stat_mismatch = mis_q;
  assign stat_cycles   = cycles;

endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic              stat_busy,
  input logic              stat_done,
  input logic              stat_timeout,
  input logic              stat_mismatch,
  input logic [CNT_W-1:0]  stat_cycles,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_ready
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> (!tx_valid && !rx_ready)); // R1

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cfg_start) |=> (tx_valid && $stable(tx_data))); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |-> !stat_busy); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_done && !cfg_start) |=> (stat_done && $stable(stat_cycles))); // R3

  AST_TIMEOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_timeout |-> stat_done); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_busy && !cfg_start) |=> (stat_cycles >= $past(stat_cycles))); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> (!stat_timeout && !stat_mismatch && (stat_cycles == '0))); // R10

endmodule

bind linktest_core lt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lt_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_start     (cfg_start),
  .stat_busy     (stat_busy),
  .stat_done     (stat_done),
  .stat_timeout  (stat_timeout),
  .stat_mismatch (stat_mismatch),
  .stat_cycles   (stat_cycles),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .rx_ready      (rx_ready)
);

// File: tb/linktest_core_tb.sv
module linktest_core_tb;

  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int CW    = 12;
  localparam int CMAX  = (1 << CW) - 1;

  localparam int S_IDLE = 0, S_SRC = 1, S_SNK = 2, S_PTX = 3, S_PRX = 4, S_ECHO = 5;

  logic          clk, rst_n;
  logic          cfg_start;
  logic [1:0]    cfg_mode;
  logic [CW-1:0] cfg_count, cfg_limit;
  logic          stat_busy, stat_done, stat_timeout, stat_mismatch;
  logic [CW-1:0] stat_cycles;
  logic          tx_valid, tx_ready, rx_valid, rx_ready;
  logic [DW-1:0] tx_data, rx_data;

  int checks = 0;
  int errors = 0;

  linktest_core #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_count(cfg_count), .cfg_limit(cfg_limit), .stat_busy(stat_busy),
    .stat_done(stat_done), .stat_timeout(stat_timeout), .stat_mismatch(stat_mismatch),
    .stat_cycles(stat_cycles), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_words, m_target, m_limit, m_ping;
  bit m_done, m_tmo, m_mis;
  int m_q[$];

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic bit m_txv();
    return (m_st == S_SRC) || (m_st == S_PTX) || (m_st == S_ECHO && m_q.size() > 0);
  endfunction

  function automatic int m_txd();
    if (m_st == S_SRC) return m_words;
    if (m_st == S_PTX) return m_ping;
    return m_q[0];
  endfunction

  function automatic bit m_rxr();
    return (m_st == S_SNK) || (m_st == S_PRX) || (m_st == S_ECHO && m_q.size() == 0);
  endfunction

  always @(posedge clk) begin
    bit htx, hrx;
    if (!rst_n) begin
      m_st = S_IDLE; m_cnt = 0; m_words = 0; m_target = 0; m_limit = 0; m_ping = 0;
      m_done = 0; m_tmo = 0; m_mis = 0; m_q.delete();
    end else begin
      htx = m_txv() && tx_ready;
      hrx = m_rxr() && rx_valid;
      if (cfg_start) begin
        m_done = 0; m_tmo = 0; m_mis = 0; m_cnt = 0; m_words = 0;
        m_target = int'(cfg_count); m_limit = int'(cfg_limit); m_ping = int'(cfg_count);
        m_q.delete();
        case (int'(cfg_mode))
          0: if (cfg_count == 0) begin m_st = S_IDLE; m_done = 1; end else m_st = S_SRC;
          1: if (cfg_count == 0) begin m_st = S_IDLE; m_done = 1; end else m_st = S_SNK;
          2: m_st = S_PTX;
          default: m_st = S_ECHO;
        endcase
      end else begin
        case (m_st)
          S_SRC: begin
            m_cnt = sat(m_cnt + 1);
            if (htx) begin
              m_words++;
              if (m_words == m_target) begin m_st = S_IDLE; m_done = 1; end
            end
          end
          S_SNK: begin
            m_cnt = sat(m_cnt + 1);
            if (hrx) begin
              if (int'(rx_data) != m_words) m_mis = 1;
              m_words++;
              if (m_words == m_target) begin m_st = S_IDLE; m_done = 1; end
            end
          end
          S_PTX: if (htx) m_st = S_PRX;
          S_PRX: begin
            m_cnt = sat(m_cnt + 1);
            if (hrx) begin
              m_st = S_IDLE; m_done = 1; m_mis = (int'(rx_data) != m_ping);
            end else if (m_limit != 0 && m_cnt >= m_limit) begin
              m_st = S_IDLE; m_done = 1; m_tmo = 1;
            end
          end
          S_ECHO: begin
            if (htx) begin void'(m_q.pop_front()); m_cnt = sat(m_cnt + 1); end
            if (hrx) m_q.push_back(int'(rx_data));
          end
          default: ;
        endcase
      end
    end
    #(CLK_P/4);
    chk(stat_busy == (m_st != S_IDLE), "R3 busy", stat_busy, m_st != S_IDLE);
    chk(stat_done == m_done, "R3 done", stat_done, m_done);
    chk(stat_timeout == m_tmo, "R7 timeout", stat_timeout, m_tmo);
    chk(stat_mismatch == m_mis, "R5 mismatch", stat_mismatch, m_mis);
    chk(int'(stat_cycles) == m_cnt, "R9 cycles", stat_cycles, m_cnt);
    chk(tx_valid == m_txv(), "R11 tx_valid", tx_valid, m_txv());
    if (m_txv()) chk(int'(tx_data) == m_txd(), "R2 tx_data", tx_data, m_txd());
    chk(rx_ready == m_rxr(), "R4 rx_ready", rx_ready, m_rxr());
  end

  // stimulus helpers
  task automatic start_test(input int mode, input int cnt, input int lim);
    @(negedge clk);
    cfg_mode  = 2'(mode);
    cfg_count = CW'(cnt);
    cfg_limit = CW'(lim);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 10000 && stat_busy; i++) @(negedge clk);
  endtask

  task automatic send_word(input int w);
    bit ok;
    rx_valid = 1'b1;
    rx_data  = DW'(w);
    forever begin
      #1;
      ok = rx_ready;
      @(negedge clk);
      if (ok) break;
    end
    rx_valid = 1'b0;
  endtask

  task automatic ping_peer(input int delay, input int flip);
    int w;
    w = int'(tx_data);
    @(negedge clk);
    repeat (delay) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = DW'(w ^ flip);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_start = 1'b0; cfg_mode = '0; cfg_count = '0; cfg_limit = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!stat_busy && !stat_done && !tx_valid && !rx_ready, "R1 idle after reset",
        {stat_busy, stat_done, tx_valid, rx_ready}, 0);
    chk(stat_cycles == 0, "R1 cycles after reset", stat_cycles, 0);

    // R3 source, link always ready
    tx_ready = 1'b1;
    start_test(0, 5, 0);
    wait_idle();
    chk(stat_cycles == 5, "R3 source 5 words free link", stat_cycles, 5);
    chk(stat_done, "R3 source done", stat_done, 1);

    // R2 source under alternating back-pressure
    tx_ready = 1'b0;
    start_test(0, 6, 0);
    while (stat_busy) begin
      @(negedge clk);
      tx_ready = ~tx_ready;
    end
    chk(stat_cycles == 12, "R2 source 6 words half-rate link", stat_cycles, 12);
    tx_ready = 1'b0;

    // R4 sink with gaps
    start_test(1, 4, 0);
    for (int k = 0; k < 4; k++) begin
      send_word(k);
      repeat (k) @(negedge clk);
    end
    wait_idle();
    chk(stat_done && !stat_mismatch, "R4 sink in order", {stat_done, stat_mismatch}, 2);

    // R5 sink sees a sequence break
    start_test(1, 3, 0);
    send_word(0);
    send_word(2);
    send_word(2);
    wait_idle();
    chk(stat_mismatch, "R5 sink sequence break", stat_mismatch, 1);

    // R6 ping with good echo
    tx_ready = 1'b1;
    start_test(2, 'hABC, 0);
    chk(int'(tx_data) == 'hABC, "R6 ping payload", tx_data, 'hABC);
    ping_peer(6, 0);
    wait_idle();
    chk(stat_cycles == 7, "R6 round trip count", stat_cycles, 7);
    chk(stat_done && !stat_mismatch && !stat_timeout, "R6 clean reply",
        {stat_done, stat_mismatch, stat_timeout}, 4);

    // R6 ping with corrupted echo
    start_test(2, 'h5A5, 0);
    ping_peer(2, 1);
    wait_idle();
    chk(stat_cycles == 3 && stat_mismatch, "R6 corrupted reply", stat_cycles, 3);

    // R7 timeout
    start_test(2, 'h123, 9);
    wait_idle();
    chk(stat_timeout && stat_done, "R7 timeout flags", {stat_timeout, stat_done}, 3);
    chk(stat_cycles == 9, "R7 timeout count", stat_cycles, 9);
    chk(!rx_ready, "R7 ready dropped", rx_ready, 0);

    // R8 responder
    tx_ready = 1'b0;
    start_test(3, 0, 0);
    send_word('h1234);
    chk(!rx_ready && tx_valid && tx_data == 'h1234, "R8 held word blocks input",
        {rx_ready, tx_valid}, 1);
    tx_ready = 1'b1;
    @(negedge clk);
    send_word('h55AA);
    @(negedge clk);
    send_word('h0F0F);
    repeat (3) @(negedge clk);
    chk(stat_cycles == 3 && !stat_done && stat_busy, "R8 three echoes", stat_cycles, 3);

    // R9 saturation, R10 abort of responder
    tx_ready = 1'b0;
    start_test(1, 2, 0);
    repeat (4200) @(negedge clk);
    chk(stat_cycles == CMAX, "R9 saturated count", stat_cycles, CMAX);
    chk(stat_busy, "R9 still waiting", stat_busy, 1);

    // R10 zero count finishes at once
    start_test(0, 0, 0);
    chk(stat_done && !stat_busy && stat_cycles == 0, "R10 zero count", stat_cycles, 0);

    // R10 new start clears done
    start_test(0, 3, 0);
    chk(!stat_done && stat_cycles == 0, "R10 start clears done", stat_done, 0);
    tx_ready = 1'b1;
    wait_idle();
    chk(stat_cycles == 3, "R10 fresh source count", stat_cycles, 3);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule